// File: doc/BRIEF.md
# Strobe-Framed Two-Lane Serial Word Deserializer

This block rebuilds parallel words from a set of bit-serial lanes that arrive together with their own clock and a framing strobe. Each lane carries one byte of the word. On every clock edge, each lane's current bit is shifted into a private byte-wide register. This shifting never pauses, so a lane register always holds the most recent bits from its lane.

The framing strobe is active for one clock in every eight and marks the word boundary. Word boundaries are not found from a bit counter or from a pattern in the data: the strobe alone decides when a word is taken. In the cycle the strobe is sampled active, the byte each lane has just completed (including the bit present in that cycle) is copied into a word-wide holding register. In the following cycle, a valid flag is high for one clock. Between strobes the holding register keeps its value, so downstream logic can read it at leisure.

Lane count, byte width, strobe polarity and bit order are parameters. The defaults are two lanes of eight bits, an active-low strobe and least-significant-bit-first transmission.

Top module: `sdm_deserializer`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released until the first strobe, `word_out` is all zeros and `word_vld` is 0.
- R2: Bits arrive least significant bit first. The lane bit present in the strobe cycle lands in bit 7 of that lane's byte. The bit present seven cycles earlier lands in bit 0.
- R3: Lane 0 fills `word_out[7:0]` and lane 1 fills `word_out[15:8]`.
- R4: `word_out` changes only at the clock edge where `frame_strobe` is sampled low (active). At every other edge it keeps its value.
- R5: `word_vld` is high for exactly the one cycle after each edge where the strobe was sampled active. After an edge where the strobe was inactive, it is low.
- R6: Shifting continues on every clock whatever the strobe does. When strobes are more than eight cycles apart, the word holds only the last eight bits of each lane, and older bits are discarded.
- R7: Strobes on two consecutive cycles each produce a word. `word_vld` then stays high for two cycles, and the second word is the first word shifted by one bit position, with the newest lane bit entering at the top of each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 2 | One serial data bit per lane; bit 0 is lane 0 |
| frame_strobe | input | 1 | Word boundary marker, active low for one cycle in eight |
| word_out | output | 16 | Last captured word; lane 0 in the low byte |
| word_vld | output | 1 | One-cycle pulse after each capture |

## Verification
A wrong bit order or lane placement inside a shift register shows up in `word_out` at the first capture after the fault, one edge after the strobe. A mis-decoded strobe polarity or a broken valid register makes `word_vld` pulse in the wrong cycles, visible one edge after any strobe or non-strobe cycle. A capture enable that leaks outside the strobe cycle shows as `word_out` drifting during the seven idle cycles of a frame. A shift register that stalls between strobes surfaces only when frames are longer than eight cycles, as stale bits in the next captured word.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   // Bit position inside a lane byte that receives the newest serial bit.
   function automatic int newest_bit_pos(input int byte_w, input bit msb_first);
      return msb_first ? 0 : byte_w - 1;
   endfunction

endpackage

// File: rtl/sdm_lane_shifter.sv
module sdm_lane_shifter #(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   output logic [BYTE_W-1:0] byte_next
);

   logic [BYTE_W-1:0] shreg;

   generate
      if (MSB_FIRST) begin : g_msb_first
         always_comb byte_next = {shreg[BYTE_W-2:0], ser_bit};
      end else begin : g_lsb_first
         always_comb byte_next = {ser_bit, shreg[BYTE_W-1:1]};
      end
   endgenerate

   // Shifts on every edge; framing never stalls the lane.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= byte_next;
   end

endmodule

// File: rtl/sdm_boundary_detect.sv
module sdm_boundary_detect #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic strobe_raw,
   output logic boundary
);

   generate
      if (ACTIVE_LOW) begin : g_act_low
         assign boundary = ~strobe_raw;
      end else begin : g_act_high
         assign boundary = strobe_raw;
      end
   endgenerate

endmodule

// File: rtl/sdm_word_capture.sv
module sdm_word_capture #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_q,
   output logic              vld_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= boundary;
         if (boundary) word_q <= word_in;
      end
   end

endmodule

// File: rtl/sdm_deserializer.sv
module sdm_deserializer #(
   parameter int LANES             = 2,
   parameter int BYTE_W            = 8,
   parameter bit STROBE_ACTIVE_LOW = 1'b1,
   parameter bit MSB_FIRST         = 1'b0,
   localparam int WORD_W           = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  lane_in,
   input  logic              frame_strobe,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("sdm_deserializer: LANES must be at least 1");
      end
      if (BYTE_W < 2) begin : g_bad_width
         $error("sdm_deserializer: BYTE_W must be at least 2");
      end
   endgenerate

   logic              boundary;
   logic [WORD_W-1:0] word_next;

   sdm_boundary_detect #(.ACTIVE_LOW(STROBE_ACTIVE_LOW)) u_bdet (
      .strobe_raw (frame_strobe),
      .boundary   (boundary)
   );

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [BYTE_W-1:0] lane_byte;
         sdm_lane_shifter #(.BYTE_W(BYTE_W), .MSB_FIRST(MSB_FIRST)) u_shift (
            .clk       (clk),
            .rst_n     (rst_n),
            .ser_bit   (lane_in[ln]),
            .byte_next (lane_byte)
         );
         assign word_next[ln*BYTE_W +: BYTE_W] = lane_byte;
      end
   endgenerate

   sdm_word_capture #(.WORD_W(WORD_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (boundary),
      .word_in  (word_next),
      .word_q   (word_out),
      .vld_q    (word_vld)
   );

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
   parameter int LANES             = 2,
   parameter int BYTE_W            = 8,
   parameter bit STROBE_ACTIVE_LOW = 1'b1,
   parameter bit MSB_FIRST         = 1'b0,
   localparam int WORD_W           = LANES * BYTE_W,
   localparam int NEWEST           = sdm_pkg::newest_bit_pos(BYTE_W, MSB_FIRST)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LANES-1:0]  lane_in,
   input logic              frame_strobe,
   input logic [WORD_W-1:0] word_out,
   input logic              word_vld
);

   logic mark;
   assign mark = STROBE_ACTIVE_LOW ? !frame_strobe : frame_strobe;

   AST_VLD_AFTER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      mark |=> word_vld); // R5

   AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mark |=> !word_vld); // R5

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mark |=> $stable(word_out)); // R4

   AST_LOW_LANE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      mark |=> word_out[NEWEST] == $past(lane_in[0])); // R2

   generate
      if (LANES > 1) begin : g_hi_lane
         AST_HIGH_LANE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
            mark |=> word_out[BYTE_W + NEWEST] == $past(lane_in[1])); // R3
      end
   endgenerate

endmodule

bind sdm_deserializer sdm_checker #(
   .LANES(LANES), .BYTE_W(BYTE_W),
   .STROBE_ACTIVE_LOW(STROBE_ACTIVE_LOW), .MSB_FIRST(MSB_FIRST)
) u_sdm_checker (
   .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .frame_strobe(frame_strobe),
   .word_out(word_out), .word_vld(word_vld)
);

// File: tb/tb_sdm_deserializer.sv
`timescale 1ns/1ps
module tb_sdm_deserializer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  lane_in = 2'b00;
   logic        frame_strobe = 1'b1;
   logic [15:0] word_out;
   logic        word_vld;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [15:0] last_word = 16'h0000;

   always #4 clk = ~clk;

   sdm_deserializer dut (
      .clk(clk), .rst_n(rst_n), .lane_in(lane_in),
      .frame_strobe(frame_strobe), .word_out(word_out), .word_vld(word_vld)
   );

   localparam int NVEC = 6;
   localparam logic [15:0] VEC [NVEC] = '{16'hA55A, 16'hFFFF, 16'h0000,
                                         16'h0180, 16'h8001, 16'h3CC3};

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Eight bit-times per word, strobe active on the eighth; checks hold on the first.
   task automatic send_word(input logic [15:0] w);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 0) begin
            check("R5 idle valid", {15'd0, word_vld}, 16'd0);
            check("R4 hold", word_out, last_word);
         end
         lane_in[0]   = w[i];
         lane_in[1]   = w[8+i];
         frame_strobe = (i == 7) ? 1'b0 : 1'b1;
      end
      @(negedge clk);
      frame_strobe = 1'b1;
      lane_in      = 2'b00;
      check("R5 valid pulse", {15'd0, word_vld}, 16'd1);
      check("R2 R3 word", word_out, w);
      last_word = w;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset word", word_out, 16'h0000);
      check("R1 reset valid", {15'd0, word_vld}, 16'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 idle word", word_out, 16'h0000);
      check("R1 idle valid", {15'd0, word_vld}, 16'd0);

      // R2/R3/R4/R5: vector table
      for (int v = 0; v < NVEC; v++) send_word(VEC[v]);

      // R6: long frame, only the last eight bits survive
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         lane_in = 2'b11;
         frame_strobe = 1'b1;
      end
      send_word(16'h1234);
      check("R6 stale bits dropped", last_word, 16'h1234);

      // R7: consecutive strobes
      send_word(16'h5AC3);
      frame_strobe = 1'b0;
      lane_in      = 2'b10;
      @(negedge clk);
      frame_strobe = 1'b1;
      lane_in      = 2'b00;
      check("R7 second valid", {15'd0, word_vld}, 16'd1);
      check("R7 second word", word_out, {1'b1, 7'(8'h5A >> 1), 1'b0, 7'(8'hC3 >> 1)});
      last_word = word_out;
      @(negedge clk);
      check("R7 valid drops", {15'd0, word_vld}, 16'd0);
      check("R4 hold after pair", word_out, {8'hAD, 8'h61});

      // R1: reset in mid stream
      lane_in = 2'b11;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset word", word_out, 16'h0000);
      check("R1 mid reset valid", {15'd0, word_vld}, 16'd0);
      rst_n = 1'b1;
      lane_in = 2'b00;
      last_word = 16'h0000;
      send_word(16'hC0DE);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule